// File: doc/BRIEF.md
# Wide-to-Narrow Dual-Clock FIFO

This block carries data from one clock domain to another, accepting wide words on a write clock and handing them out as narrow beats on a separate read clock that has no frequency or phase relation to the first. With default parameters, each stored 128-bit entry is read out as eight 16-bit beats. Storage holds 1024 wide entries. Entry pointers move between the domains in Gray code through two-stage synchronizers.

The read side works in first-word-fall-through fashion. Whenever data is available, the next beat is already present on the read data output, and a read request simply moves on to the following beat. Each side has a full or empty flag and an almost flag against a threshold supplied on an input port. Each side also has an error pulse: a write refused because the FIFO is full, or a read requested while it is empty. Neither kind of refused request changes stored data or pointers. Each domain has its own active-high synchronous reset.

Top module: `afifo_asym`

## Requirements
- R1: Each stored wide entry is delivered as WR_W/RD_W read beats (eight with defaults), least-significant slice first: bits 15:0 on the first beat and bits 127:112 on the last.
- R2: While `empty` is low, `rd_data` already shows the oldest unread beat before `rd_en` is raised; a read with `rd_en` high at an rclk edge moves the output to the next beat.
- R3: Entries come out in the order they were written, with no loss or duplication, under independent write and read clocks, and all DEPTH entries can be filled.
- R4: `full` rises right after the wclk edge that stores the DEPTH-th unread entry. It falls only after reads have crossed into the write domain.
- R5: A write with `full` high stores nothing and leaves the write pointer unchanged; `wr_err` is high for the one wclk cycle after that edge and low otherwise.
- R6: `empty` is high after reset. It falls within a few rclk cycles of a write. It rises at the rclk edge that consumes the last beat of the last entry.
- R7: A read with `empty` high changes neither pointers nor data; `rd_err` is high for the one rclk cycle after that edge and low otherwise.
- R8: `almost_full` is high when the write-side entry count (writes minus synchronized reads) is at least `af_level`.
- R9: `almost_empty` is high when the read-side entry count (synchronized writes minus fully or partly consumed reads, with a partly read entry still counted) is at most `ae_level`.
- R10: `wrst` clears the write side (`full`, `wr_err` and `almost_full` low with a zero threshold excepted), and `rrst` clears the read side (`empty` high, `rd_err` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wrst | input | 1 | Write-domain synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | WR_W | Wide word to store |
| af_level | input | AW+1 | Almost-full threshold in entries |
| full | output | 1 | No free entry |
| almost_full | output | 1 | Entry count at or above af_level |
| wr_err | output | 1 | Pulse: write refused while full |
| rclk | input | 1 | Read clock |
| rrst | input | 1 | Read-domain synchronous reset, active high |
| rd_en | input | 1 | Advance to next beat |
| rd_data | output | RD_W | Current beat (first-word fall-through) |
| ae_level | input | AW+1 | Almost-empty threshold in entries |
| empty | output | 1 | No unread beat |
| almost_empty | output | 1 | Entry count at or below ae_level |
| rd_err | output | 1 | Pulse: read requested while empty |

## Verification
Several results are due at the first sampling point after an edge in their own domain: `full`, `almost_full`, `almost_empty`, `rd_data` after a read, and both error pulses. The bench drives on the falling edge and checks at the next falling edge. The fall of `empty` and the release of `full` depend on two synchronizer stages in the other domain. For those results the bench waits a fixed margin of receiving-domain cycles before checking, or polls the flag before it acts. Beat values are checked against a queue model before each read is issued, so the fall-through value is checked in the same cycle that it is consumed.

// File: rtl/afifo_pkg.sv
`timescale 1ns/1ps
package afifo_pkg;
   function automatic logic [31:0] bin2gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [31:0] gray2bin(input logic [31:0] g);
      logic [31:0] b;
      b[31] = g[31];
      for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction
endpackage

// File: rtl/afifo_sync.sv
`timescale 1ns/1ps
module afifo_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/afifo_wr_ctrl.sv
`timescale 1ns/1ps
module afifo_wr_ctrl
   import afifo_pkg::*;
#(
   parameter int PW = 11
) (
   input  logic          wclk,
   input  logic          wrst,
   input  logic          wr_en,
   input  logic [PW-1:0] af_level,
   input  logic [PW-1:0] rgray_s,
   output logic [PW-1:0] wbin,
   output logic [PW-1:0] wgray,
   output logic          wr_fire,
   output logic          full,
   output logic          almost_full,
   output logic          wr_err
);
   logic [PW-1:0] rbin_s;
   logic [PW-1:0] wlevel;
   logic [PW-1:0] full_pat;

   assign full_pat    = {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]};
   assign full        = (wgray == full_pat);
   assign wr_fire     = wr_en & ~full;
   assign rbin_s      = PW'(gray2bin(32'(rgray_s)));
   assign wlevel      = wbin - rbin_s;
   assign almost_full = (wlevel >= af_level);

   always_ff @(posedge wclk) begin
      if (wrst) begin
         wbin   <= '0;
         wgray  <= '0;
         wr_err <= 1'b0;
      end else begin
         wr_err <= wr_en & full;
         if (wr_fire) begin
            wbin  <= wbin + 1'b1;
            wgray <= PW'(bin2gray(32'(wbin + 1'b1)));
         end
      end
   end
endmodule

// File: rtl/afifo_rd_ctrl.sv
`timescale 1ns/1ps
module afifo_rd_ctrl
   import afifo_pkg::*;
#(
   parameter int PW    = 11,
   parameter int RATIO = 8,
   parameter int SW    = 3
) (
   input  logic          rclk,
   input  logic          rrst,
   input  logic          rd_en,
   input  logic [PW-1:0] ae_level,
   input  logic [PW-1:0] wgray_s,
   output logic [PW-1:0] rbin,
   output logic [PW-1:0] rgray,
   output logic [SW-1:0] slice,
   output logic          empty,
   output logic          almost_empty,
   output logic          rd_err
);
   logic          rd_fire;
   logic          last_beat;
   logic [PW-1:0] wbin_s;
   logic [PW-1:0] rlevel;

   assign empty        = (rgray == wgray_s);
   assign rd_fire      = rd_en & ~empty;
   assign wbin_s       = PW'(gray2bin(32'(wgray_s)));
   assign rlevel       = wbin_s - rbin;
   assign almost_empty = (rlevel <= ae_level);

   generate
      if (RATIO > 1) begin : g_slices
         assign last_beat = (slice == SW'(RATIO - 1));
         always_ff @(posedge rclk) begin
            if (rrst)         slice <= '0;
            else if (rd_fire) slice <= last_beat ? '0 : slice + 1'b1;
         end
      end else begin : g_noslice
         assign last_beat = 1'b1;
         assign slice     = '0;
      end
   endgenerate

   always_ff @(posedge rclk) begin
      if (rrst) begin
         rbin   <= '0;
         rgray  <= '0;
         rd_err <= 1'b0;
      end else begin
         rd_err <= rd_en & empty;
         if (rd_fire && last_beat) begin
            rbin  <= rbin + 1'b1;
            rgray <= PW'(bin2gray(32'(rbin + 1'b1)));
         end
      end
   end
endmodule

// File: rtl/afifo_store.sv
`timescale 1ns/1ps
module afifo_store #(
   parameter int WR_W  = 128,
   parameter int RD_W  = 16,
   parameter int DEPTH = 1024,
   parameter int AW    = 10,
   parameter int SW    = 3
) (
   input  logic            wclk,
   input  logic            we,
   input  logic [AW-1:0]   waddr,
   input  logic [WR_W-1:0] wdata,
   input  logic [AW-1:0]   raddr,
   input  logic [SW-1:0]   slice,
   output logic [RD_W-1:0] rdata
);
   logic [WR_W-1:0] mem [DEPTH];
   logic [WR_W-1:0] entry;

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign entry = mem[raddr];
   assign rdata = entry[32'(slice) * RD_W +: RD_W];
endmodule

// File: rtl/afifo_asym.sv
`timescale 1ns/1ps
module afifo_asym #(
   parameter int WR_W   = 128,
   parameter int RD_W   = 16,
   parameter int DEPTH  = 1024,
   parameter int STAGES = 2,
   localparam int AW    = $clog2(DEPTH),
   localparam int PW    = AW + 1,
   localparam int RATIO = WR_W / RD_W,
   localparam int SW    = (RATIO > 1) ? $clog2(RATIO) : 1
) (
   input  logic            wclk,
   input  logic            wrst,
   input  logic            wr_en,
   input  logic [WR_W-1:0] wr_data,
   input  logic [PW-1:0]   af_level,
   output logic            full,
   output logic            almost_full,
   output logic            wr_err,
   input  logic            rclk,
   input  logic            rrst,
   input  logic            rd_en,
   output logic [RD_W-1:0] rd_data,
   input  logic [PW-1:0]   ae_level,
   output logic            empty,
   output logic            almost_empty,
   output logic            rd_err
);
   generate
      if (WR_W % RD_W != 0)       begin : g_bad_ratio  $error("WR_W must be a multiple of RD_W"); end
      if ((1 << AW) != DEPTH)     begin : g_bad_depth  $error("DEPTH must be a power of two"); end
      if (DEPTH < 4)              begin : g_small      $error("DEPTH must be at least 4"); end
      if ((1 << SW) != RATIO && RATIO > 1) begin : g_bad_pow $error("WR_W/RD_W must be a power of two"); end
      if (STAGES < 2)             begin : g_bad_sync   $error("STAGES must be at least 2"); end
   endgenerate

   logic [PW-1:0] w_bin, w_gray, w_gray_s;
   logic [PW-1:0] r_bin, r_gray, r_gray_s;
   logic [SW-1:0] r_slice;
   logic          w_fire;

   afifo_wr_ctrl #(.PW(PW)) u_wr (
      .wclk(wclk), .wrst(wrst), .wr_en(wr_en), .af_level(af_level),
      .rgray_s(r_gray_s), .wbin(w_bin), .wgray(w_gray), .wr_fire(w_fire),
      .full(full), .almost_full(almost_full), .wr_err(wr_err)
   );

   afifo_sync #(.W(PW), .STAGES(STAGES)) u_r2w (
      .clk(wclk), .rst(wrst), .d(r_gray), .q(r_gray_s)
   );

   afifo_sync #(.W(PW), .STAGES(STAGES)) u_w2r (
      .clk(rclk), .rst(rrst), .d(w_gray), .q(w_gray_s)
   );

   afifo_rd_ctrl #(.PW(PW), .RATIO(RATIO), .SW(SW)) u_rd (
      .rclk(rclk), .rrst(rrst), .rd_en(rd_en), .ae_level(ae_level),
      .wgray_s(w_gray_s), .rbin(r_bin), .rgray(r_gray), .slice(r_slice),
      .empty(empty), .almost_empty(almost_empty), .rd_err(rd_err)
   );

   afifo_store #(.WR_W(WR_W), .RD_W(RD_W), .DEPTH(DEPTH), .AW(AW), .SW(SW)) u_mem (
      .wclk(wclk), .we(w_fire), .waddr(w_bin[AW-1:0]), .wdata(wr_data),
      .raddr(r_bin[AW-1:0]), .slice(r_slice), .rdata(rd_data)
   );
endmodule

// File: rtl/afifo_asym_chk.sv
`timescale 1ns/1ps
module afifo_asym_chk #(
   parameter int PW    = 11,
   parameter int SW    = 3,
   parameter int RATIO = 8
) (
   input logic          wclk,
   input logic          wrst,
   input logic          rclk,
   input logic          rrst,
   input logic          wr_en,
   input logic          full,
   input logic          wr_err,
   input logic          rd_en,
   input logic          empty,
   input logic          rd_err,
   input logic [PW-1:0] w_bin,
   input logic [PW-1:0] r_bin,
   input logic [SW-1:0] r_slice
);
   // R5
   wr_refused_flag_chk: assert property (@(posedge wclk) disable iff (wrst)
      (wr_en && full) |=> wr_err);
   // R5
   wr_refused_hold_chk: assert property (@(posedge wclk) disable iff (wrst)
      (wr_en && full) |=> $stable(w_bin));
   // R5
   wr_err_spurious_chk: assert property (@(posedge wclk) disable iff (wrst)
      !(wr_en && full) |=> !wr_err);
   // R7
   rd_refused_flag_chk: assert property (@(posedge rclk) disable iff (rrst)
      (rd_en && empty) |=> rd_err);
   // R7
   rd_refused_hold_chk: assert property (@(posedge rclk) disable iff (rrst)
      (rd_en && empty) |=> ($stable(r_bin) && $stable(r_slice)));
   // R1
   entry_advance_chk: assert property (@(posedge rclk) disable iff (rrst)
      (rd_en && !empty && r_slice == SW'(RATIO - 1)) |=> (r_bin == $past(r_bin) + 1'b1));
   // R1
   beat_hold_entry_chk: assert property (@(posedge rclk) disable iff (rrst)
      (rd_en && !empty && r_slice != SW'(RATIO - 1)) |=> $stable(r_bin));
endmodule

bind afifo_asym afifo_asym_chk #(.PW(PW), .SW(SW), .RATIO(RATIO)) u_chk (
   .wclk(wclk), .wrst(wrst), .rclk(rclk), .rrst(rrst),
   .wr_en(wr_en), .full(full), .wr_err(wr_err),
   .rd_en(rd_en), .empty(empty), .rd_err(rd_err),
   .w_bin(w_bin), .r_bin(r_bin), .r_slice(r_slice)
);

// File: tb/afifo_asym_bench.sv
`timescale 1ns/1ps
module afifo_asym_bench;
   localparam int WR_W  = 128;
   localparam int RD_W  = 16;
   localparam int DEPTH = 1024;
   localparam int PW    = $clog2(DEPTH) + 1;
   localparam int RATIO = WR_W / RD_W;

   logic            wclk = 1'b0, rclk = 1'b0;
   logic            wrst = 1'b1, rrst = 1'b1;
   logic            wr_en = 1'b0, rd_en = 1'b0;
   logic [WR_W-1:0] wr_data = '0;
   logic [PW-1:0]   af_level = PW'(4), ae_level = PW'(2);
   logic            full, almost_full, wr_err, empty, almost_empty, rd_err;
   logic [RD_W-1:0] rd_data;

   int nchk = 0, nfail = 0;
   bit done = 0;
   logic [WR_W-1:0] model [$];
   int bslice = 0;

   always #10 wclk = ~wclk;
   always #7  rclk = ~rclk;

   afifo_asym #(.WR_W(WR_W), .RD_W(RD_W), .DEPTH(DEPTH)) u_afifo_asym (
      .wclk(wclk), .wrst(wrst), .wr_en(wr_en), .wr_data(wr_data), .af_level(af_level),
      .full(full), .almost_full(almost_full), .wr_err(wr_err),
      .rclk(rclk), .rrst(rrst), .rd_en(rd_en), .rd_data(rd_data), .ae_level(ae_level),
      .empty(empty), .almost_empty(almost_empty), .rd_err(rd_err)
   );

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [WR_W-1:0] rnd_word();
      return {$urandom(), $urandom(), $urandom(), $urandom()};
   endfunction

   task automatic wr_entry(input logic [WR_W-1:0] d);
      @(negedge wclk);
      while (full) @(negedge wclk);
      wr_en = 1'b1; wr_data = d; model.push_back(d);
      @(negedge wclk);
      wr_en = 1'b0;
   endtask

   // checks the fall-through beat against the model, then consumes it
   task automatic rd_beats(input int n, input string req);
      for (int k = 0; k < n; k++) begin
         @(negedge rclk);
         while (empty) begin rd_en = 1'b0; @(negedge rclk); end
         check(req, 128'(rd_data), 128'(model[0][bslice*RD_W +: RD_W]));
         rd_en = 1'b1;
         if (bslice == RATIO - 1) begin bslice = 0; void'(model.pop_front()); end
         else bslice++;
      end
      @(negedge rclk);
      rd_en = 1'b0;
   endtask

   task automatic wait_r(input int n); repeat (n) @(negedge rclk); endtask
   task automatic wait_w(input int n); repeat (n) @(negedge wclk); endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   endtask

   initial begin
      #3000000;
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge wclk);
      wrst = 1'b0; rrst = 1'b0;
      wait_r(2);
      // R10 reset state
      check("R10 empty", 128'(empty), 128'(1));
      check("R10 rd_err", 128'(rd_err), 128'(0));
      check("R10 full", 128'(full), 128'(0));
      check("R10 wr_err", 128'(wr_err), 128'(0));
      check("R10 almost_full", 128'(almost_full), 128'(0));
      check("R9 almost_empty at zero", 128'(almost_empty), 128'(1));

      // R7 read while empty
      @(negedge rclk); rd_en = 1'b1;
      @(negedge rclk); rd_en = 1'b0;
      check("R7 rd_err pulse", 128'(rd_err), 128'(1));
      check("R7 empty held", 128'(empty), 128'(1));
      @(negedge rclk);
      check("R7 rd_err clears", 128'(rd_err), 128'(0));

      // R1 directed slice order
      wr_entry(128'h7777_6666_5555_4444_3333_2222_1111_0000);
      wait_r(4);
      check("R6 empty falls", 128'(empty), 128'(0));
      check("R1 first beat is low slice", 128'(rd_data), 128'h0000);
      rd_beats(RATIO, "R1 slice order");
      check("R6 empty rises on last beat", 128'(empty), 128'(1));

      // R8 / R9 thresholds
      for (int i = 0; i < 3; i++) wr_entry(rnd_word());
      check("R8 below level", 128'(almost_full), 128'(0));
      wr_entry(rnd_word());
      check("R8 at level", 128'(almost_full), 128'(1));
      wait_r(4);
      check("R9 above level", 128'(almost_empty), 128'(0));
      rd_beats(RATIO, "R2 beats");
      check("R9 three left", 128'(almost_empty), 128'(0));
      rd_beats(1, "R2 beats");
      check("R9 partial entry counted", 128'(almost_empty), 128'(0));
      rd_beats(RATIO - 1, "R2 beats");
      check("R9 two left", 128'(almost_empty), 128'(1));
      rd_beats(2 * RATIO, "R3 drain");
      wait_w(5);
      check("R8 falls after reads", 128'(almost_full), 128'(0));

      // R4 / R5 fill to capacity
      af_level = PW'(DEPTH);
      for (int i = 0; i < DEPTH - 1; i++) wr_entry(rnd_word());
      check("R4 not full one short", 128'(full), 128'(0));
      wr_entry(rnd_word());
      check("R4 full", 128'(full), 128'(1));
      check("R8 full level", 128'(almost_full), 128'(1));
      @(negedge wclk); wr_en = 1'b1; wr_data = '1;
      @(negedge wclk); wr_en = 1'b0;
      check("R5 wr_err pulse", 128'(wr_err), 128'(1));
      check("R5 still full", 128'(full), 128'(1));
      @(negedge wclk);
      check("R5 wr_err clears", 128'(wr_err), 128'(0));
      rd_beats(RATIO, "R3 after refused write");
      wait_w(5);
      check("R4 full releases", 128'(full), 128'(0));
      rd_beats((DEPTH - 1) * RATIO, "R3 full drain");
      check("R6 empty after drain", 128'(empty), 128'(1));
      check("R3 model drained", 128'(model.size()), 128'(0));

      // R3 concurrent random traffic
      fork
         for (int i = 0; i < 60; i++) begin
            repeat ($urandom_range(0, 12)) @(negedge wclk);
            wr_entry(rnd_word());
         end
         begin
            wait_r(3);
            for (int i = 0; i < 60; i++) begin
               repeat ($urandom_range(0, 3)) @(negedge rclk);
               rd_beats(RATIO, "R3 random traffic");
            end
         end
      join
      wait_r(2);
      check("R6 empty at end", 128'(empty), 128'(1));
      finish_run();
   end
endmodule